// File: doc/BRIEF.md
# Parallel Nonvolatile Byte Memory Bus Model

This block is a clocked, synthesizable model of a byte-wide nonvolatile memory as a host sees it at its asynchronous bus pins. Three active-low strobes (chip select, output enable, write strobe) are sampled on every clock edge along with an 11-bit address. A split data bus carries write data in, and read data out together with a drive-enable. The drive-enable stands for the point at which a real pad would leave high impedance. The model holds a 2048 x 8 storage array.

A byte write takes its address at the moment the write condition forms and its data at the moment the condition ends. The block then runs an internal write cycle that times itself and needs no further bus activity. While that cycle runs, any read returns a data-polling byte, so the host can tell when the write starts and when it finishes. Writes are refused in several cases: while output enable is low, while either write strobe is high, for pulses that are too short, while a write is already running, and for a fixed time after reset.

Top module: `pmem_bus_model`

## Requirements
- R1: The array holds 2048 bytes selected by `addr[10:0]`, and every byte reads 8'hFF after reset.
- R2: `data_oe` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1. Outside that state the bus is treated as high impedance.
- R3: A write condition exists only when `ce_n`=0, `we_n`=0 and `oe_n`=1. If `oe_n` is low at any edge during the pulse, the attempt is cancelled and nothing is stored.
- R4: The address is captured on the first edge at which the write condition is seen, which is when the later of `ce_n` and `we_n` falls. The data is captured on the first edge at which `ce_n` or `we_n` is seen high again. A write works the same way whether `we_n` or `ce_n` is the controlling strobe.
- R5: A write condition seen on fewer than MIN_PULSE consecutive edges is rejected as a glitch.
- R6: For LOCK_CYCLES cycles after reset is released, no write is accepted.
- R7: After data capture, the internal write is busy for WR_CYCLES cycles. During that time a read returns `{~d[7], 7'b0}`, where d is the byte being written. After it finishes, a read returns the stored byte.
- R8: Write attempts made while busy are ignored and leave the latched address and data unchanged.
- R9: The internal write erases the target byte before programming it, so the stored value is exactly the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read or polling data |
| data_oe | output | 1 | Data bus drive enable |

## Verification
A wrong latched address or data byte, or an erase that never happens, only shows up once the internal write has finished. It appears as a wrong byte on a later read, about WR_CYCLES cycles after the strobe is released. Timer or state errors show up sooner: a wrong polling byte on the first read after a write, or a write that lands when it should have been refused (lockout, glitch, output enable low, or busy). The bench reads back both the target address and any address that a faulty latch could have hit.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ARMED = 2'd1,
        WS_BUSY  = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] poll_byte(input logic [DATA_W-1:0] d);
        return {~d[DATA_W-1], {(DATA_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/pmem_lockout.sv
module pmem_lockout #(
    parameter int LOCK_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    output logic locked
);
    localparam int W = $clog2(LOCK_CYCLES + 1);
    localparam logic [W-1:0] LIM = W'(LOCK_CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign locked = (cnt != LIM);
endmodule

// File: rtl/pmem_wr_fsm.sv
module pmem_wr_fsm
    import pmem_pkg::*;
#(
    parameter int WR_CYCLES = 2000000,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              locked,
    output logic              armed,
    output logic              busy,
    output wr_req_t           req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int TW = $clog2(WR_CYCLES);
    localparam int PW = $clog2(MIN_PULSE + 1);
    localparam logic [TW-1:0] TLIM = TW'(WR_CYCLES - 1);
    localparam logic [PW-1:0] PLIM = PW'(MIN_PULSE);

    wr_state_e     state;
    logic          cond, cond_q, ends;
    logic [TW-1:0] tmr;
    logic [PW-1:0] pcnt;

    assign cond = !ce_n && !we_n && oe_n;
    assign ends = ce_n || we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WS_IDLE;
            cond_q <= 1'b0;
            tmr    <= '0;
            pcnt   <= '0;
            req    <= '0;
        end else begin
            cond_q <= cond;
            case (state)
                WS_IDLE: begin
                    if (cond && !cond_q && !locked) begin
                        state    <= WS_ARMED;
                        req.addr <= addr;
                        pcnt     <= PW'(1);
                    end
                end
                WS_ARMED: begin
                    if (!oe_n) begin
                        state <= WS_IDLE;
                    end else if (ends) begin
                        if (pcnt >= PLIM) begin
                            req.data <= din;
                            tmr      <= '0;
                            state    <= WS_BUSY;
                        end else begin
                            state <= WS_IDLE;
                        end
                    end else if (pcnt != PLIM) begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                WS_BUSY: begin
                    if (tmr == TLIM)
                        state <= WS_IDLE;
                    else
                        tmr <= tmr + 1'b1;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign armed     = (state == WS_ARMED);
    assign busy      = (state == WS_BUSY);
    assign mem_we    = busy && ((tmr == '0) || (tmr == TLIM));
    assign mem_addr  = req.addr;
    assign mem_wdata = (tmr == TLIM) ? req.data : '1;
endmodule

// File: rtl/pmem_array.sv
module pmem_array
    import pmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pmem_bus_model.sv
module pmem_bus_model
    import pmem_pkg::*;
#(
    parameter int WR_CYCLES   = 2000000,
    parameter int LOCK_CYCLES = 1000000,
    parameter int MIN_PULSE   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    logic              locked, armed, busy, mem_we;
    wr_req_t           req;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, rdata;

    pmem_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst(rst), .locked(locked)
    );

    pmem_wr_fsm #(.WR_CYCLES(WR_CYCLES), .MIN_PULSE(MIN_PULSE)) u_fsm (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(data_in), .locked(locked), .armed(armed),
        .busy(busy), .req(req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    pmem_array u_mem (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_addr),
        .wdata(mem_wdata), .raddr(addr), .rdata(rdata)
    );

    assign data_oe  = !ce_n && !oe_n && we_n;
    assign data_out = busy ? poll_byte(req.data) : rdata;
endmodule

// File: rtl/pmem_bus_chk.sv
module pmem_bus_chk
    import pmem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              oe_n,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              busy,
    input logic              armed,
    input logic              locked,
    input wr_req_t           req
);
    AST_POLL_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (busy && data_oe) |-> (data_out[DATA_W-2:0] == '0)); // R7

    AST_NO_ARM_LOCKED: assert property (@(posedge clk) disable iff (rst)
        locked |=> !armed); // R6

    AST_UNLOCK_STAYS: assert property (@(posedge clk) disable iff (rst)
        !locked |=> !locked); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(req.addr) && $stable(req.data))); // R8

    AST_OE_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (armed && !oe_n) |=> !busy); // R3

    AST_BUSY_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed)); // R4
endmodule

bind pmem_bus_model pmem_bus_chk u_chk (
    .clk(clk), .rst(rst), .oe_n(oe_n), .data_oe(data_oe),
    .data_out(data_out), .busy(busy), .armed(armed),
    .locked(locked), .req(req)
);

// File: tb/pmem_bus_model_tb.sv
`timescale 1ns/1ps
module pmem_bus_model_tb;
    localparam int WR   = 20;
    localparam int LOCK = 30;
    localparam int MINP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic       oe;
        logic [7:0] d;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pmem_bus_model #(.WR_CYCLES(WR), .LOCK_CYCLES(LOCK), .MIN_PULSE(MINP)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    // monitor: pops one expected item per sample point
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (data_oe !== it.oe) begin
                fails++;
                $display("FAIL %s: data_oe=%b expected %b", it.tag, data_oe, it.oe);
            end else if (it.oe && data_out !== it.d) begin
                fails++;
                $display("FAIL %s: data_out=%h expected %h", it.tag, data_out, it.d);
            end
        end
    end

    task automatic push_check(input logic oe, input logic [7:0] d, input string tag);
        exp_t it;
        it.oe = oe; it.d = d; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic bus_check(input logic c, input logic o, input logic w,
                             input logic [10:0] a, input logic oe,
                             input logic [7:0] d, input string tag);
        @(posedge clk); #1;
        ce_n = c; oe_n = o; we_n = w; addr = a;
        push_check(oe, d, tag);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic read_chk(input logic [10:0] a, input logic [7:0] d, input string tag);
        bus_check(1'b0, 1'b0, 1'b1, a, 1'b1, d, tag);
    endtask

    task automatic write_op(input logic [10:0] a, input logic [10:0] a_late,
                            input logic [7:0] d_early, input logic [7:0] d,
                            input bit ce_ctl, input int len);
        @(posedge clk); #1;
        addr = a; data_in = d_early; oe_n = 1'b1;
        if (ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
        @(posedge clk); #1;
        if (ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
        @(posedge clk); #1;
        addr = a_late; data_in = d;
        repeat (len - 1) @(posedge clk);
        #1;
        if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
        @(posedge clk); #1;
        ce_n = 1'b1; we_n = 1'b1; data_in = '0;
    endtask

    task automatic settle();
        repeat (WR + 6) @(posedge clk);
        #1;
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state: all strobes high, bus not driven
        bus_check(1'b1, 1'b1, 1'b1, 11'h000, 1'b0, 8'h00, "R2 idle after reset");

        // R6: write during lockout must not land
        write_op(11'h005, 11'h005, 8'hA5, 8'hA5, 1'b0, 3);
        repeat (LOCK + 10) @(posedge clk);
        read_chk(11'h005, 8'hFF, "R6 lockout write dropped");
        // R1: untouched top byte is erased value
        read_chk(11'h7FF, 8'hFF, "R1 reset content");

        // R7 write-strobe controlled write, polling then true data
        write_op(11'h123, 11'h123, 8'h3C, 8'h3C, 1'b0, 3);
        read_chk(11'h123, 8'h80, "R7 polling inverts bit7 (0x3C)");
        settle();
        read_chk(11'h123, 8'h3C, "R7 stored after busy");

        // R4 chip-select controlled, address taken at start, data at end
        write_op(11'h7FF, 11'h7FE, 8'h00, 8'hA5, 1'b1, 3);
        read_chk(11'h7FF, 8'h00, "R7 polling inverts bit7 (0xA5)");
        settle();
        read_chk(11'h7FF, 8'hA5, "R4 early address, late data");
        read_chk(11'h7FE, 8'hFF, "R4 late address not written");

        // R9 overwrite is exact, not a merge
        write_op(11'h123, 11'h123, 8'h81, 8'h81, 1'b0, 3);
        settle();
        read_chk(11'h123, 8'h81, "R9 overwrite exact");

        // R8 write attempt while busy is ignored
        write_op(11'h010, 11'h010, 8'h11, 8'h11, 1'b0, 3);
        write_op(11'h020, 11'h020, 8'h22, 8'h22, 1'b0, 3);
        settle();
        read_chk(11'h010, 8'h11, "R8 first write kept");
        read_chk(11'h020, 8'hFF, "R8 busy write ignored");

        // R5 one-edge glitch rejected
        write_op(11'h030, 11'h030, 8'h33, 8'h33, 1'b0, 1);
        settle();
        read_chk(11'h030, 8'hFF, "R5 glitch rejected");

        // R3 output enable low throughout inhibits
        @(posedge clk); #1;
        addr = 11'h040; data_in = 8'h44; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        settle();
        read_chk(11'h040, 8'hFF, "R3 oe low inhibits");

        // R3 output enable dropping mid-pulse cancels
        @(posedge clk); #1;
        addr = 11'h050; data_in = 8'h55; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 oe_n = 1'b0;
        @(posedge clk); #1 ce_n = 1'b1; we_n = 1'b1;
        @(posedge clk); #1 oe_n = 1'b1;
        settle();
        read_chk(11'h050, 8'hFF, "R3 oe drop cancels");

        // R2 drive gating
        bus_check(1'b1, 1'b0, 1'b1, 11'h123, 1'b0, 8'h00, "R2 chip deselected");
        bus_check(1'b0, 1'b1, 1'b1, 11'h123, 1'b0, 8'h00, "R2 output disabled");
        bus_check(1'b0, 1'b0, 1'b0, 11'h123, 1'b0, 8'h00, "R2 write strobe low");
        read_chk(11'h123, 8'h81, "R2 byte unchanged by gated cycles");

        repeat (3) @(posedge clk);
        report();
    end
endmodule